// File: doc/BRIEF.md
# I2C Register Target

This block lets a two-wire bus controller reach a register file that uses 16-bit addresses. It recognises its own 7-bit bus address, takes a two-byte register pointer (high byte first), and then either stores any number of data bytes at consecutive addresses or, after a repeated START with the read bit set, returns bytes from consecutive addresses until the controller declines a byte. SDA is driven open-drain: the block only ever pulls the line low.

A small set of registers is decoded inside the block because their behaviour is special. A status register collects event pulses and clears when read. A software-reset register emits a one-cycle reset pulse to the rest of the register bank and always reads back zero. An enable register holds the device-enable bit. A revision register is read-only. All other addresses are forwarded on a simple strobe interface. Writes into a restricted address window are forwarded only while the device is disabled.

Top module: `i2c_regtarget`

## Requirements
- R1: Only an address byte whose upper 7 bits equal DEV_ADDR (default 0x39) is acknowledged. After any other address the target leaves SDA released until the next START, so later bytes see no acknowledge and cause no write.
- R2: A write transfer is the address byte with bit 0 = 0, then the pointer high byte, then the pointer low byte, then data bytes. Every byte is acknowledged. Each data byte gives exactly one single-cycle reg_wr_o at the current pointer, and the pointer then steps by one, wrapping from 0xFFFF to 0x0000.
- R3: A read is a pointer write, a repeated START and the address byte with bit 0 = 1. The target returns bytes from consecutive addresses, most significant bit first, with one reg_rd_o per byte actually sent. It continues until the controller answers a byte with a not-acknowledge, then releases SDA.
- R4: A START or STOP before the acknowledge slot of a byte discards that byte. No write is made for it.
- R5: At status address 0x2001, bit i is set by a high cycle of status_evt_i[i]. A read returns the collected bits and clears them, so an immediate second read returns 0x00.
- R6: Writing a byte with bit 0 = 1 to address 0x2000 gives one single-cycle soft_rst_o pulse and clears the device enable. Writing 0x00 there does nothing. Reading 0x2000 returns 0x00.
- R7: Bit 0 of address 0x20FF is the device enable. It drives dev_en_o, reads back in bit 0, and is 0 after reset.
- R8: Writes to addresses 0x2080 to 0x208F reach reg_wr_o only while dev_en_o is 0. Otherwise they are acknowledged and dropped. Addresses just outside the window are unaffected.
- R9: Address 0x21FF reads REV_VALUE (default 0x41), and writes to it change nothing.
- R10: The four local addresses 0x2000, 0x2001, 0x20FF and 0x21FF never raise reg_wr_o or reg_rd_o.
- R11: After reset SDA is released. It is pulled low only in an acknowledge slot or for a 0 data bit, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release |
| reg_addr_o | output | AW | Current register pointer |
| reg_wdata_o | output | 8 | Write data, valid with reg_wr_o |
| reg_wr_o | output | 1 | One-cycle write strobe to the external bank |
| reg_rd_o | output | 1 | One-cycle read strobe; reg_rdata_i sampled in this cycle |
| reg_rdata_i | input | 8 | Read data from the external bank for reg_addr_o |
| status_evt_i | input | 8 | Event pulses that set status bits |
| dev_en_o | output | 1 | Device enable bit |
| soft_rst_o | output | 1 | One-cycle reset pulse for external control registers |

## Verification
The assertions take it as given that SCL stays high and low for several system clocks. This lets a two-stage synchroniser see every edge, and lets SDA output changes, which follow a falling edge by about three clocks, land while the pin is still low. They also take it as given that the controller moves SDA only while SCL is low, except to form START and STOP. The stimulus drives every bus phase for five clocks, so each SCL half-period lasts ten clocks. It changes its SDA level one phase after SCL falls. It reads reg_rdata_i from a combinational model of the external bank, so the data is valid in the cycle of the read strobe.

// File: rtl/i2c_regtarget_pkg.sv
// Shared types for the I2C register target.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package i2c_regtarget_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_RX,     // shifting in a byte
        ST_ACK,    // holding SDA low for the acknowledge slot
        ST_LOAD,   // fetching a byte to transmit
        ST_TX,     // shifting out a byte
        ST_MACK,   // listening to the controller's acknowledge
        ST_SKIP    // not addressed, wait for START or STOP
    } link_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR_HI,
        PH_PTR_LO,
        PH_DATA
    } rx_phase_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Brings SCL and SDA into the clk domain and flags bus events.
// Assumes: bus levels are stable for more than STAGES+1 clocks per phase;
// no glitch filtering beyond the synchroniser.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Synchroniser chains plus one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    // Event decode on the synchronised levels.
    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        bus_start = scl_s & scl_q & sda_q & ~sda_s;
        bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/i2c_link_engine.sv
// Bus protocol engine: address match, two-byte pointer, write bursts and
// read bursts with auto-increment. Data is fetched only for bytes that
// will really be sent, so clear-on-read side effects never get lost.
// Assumes: rd_data is valid in the cycle rd_stb is high; AW >= 9.
module i2c_link_engine
    import i2c_regtarget_pkg::*;
#(
    parameter int         AW       = 16,
    parameter logic [6:0] DEV_ADDR = 7'h39
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          bus_start,
    input  logic          bus_stop,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ptr,
    output logic [7:0]    wr_data,
    output logic          wr_stb,
    output logic          rd_stb,
    output logic          sda_low
);
    localparam logic [AW-1:0] PTR_STEP = AW'(1);

    link_state_t state;
    rx_phase_t   phase;
    logic [7:0]  shreg;
    logic [2:0]  bitcnt;
    logic        got8;
    logic        rnw;
    logic        mack_ok;

    // Protocol sequencer; strobes are single-cycle, pointer steps after each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase   <= PH_ADDR;
            shreg   <= '0;
            bitcnt  <= '0;
            got8    <= 1'b0;
            rnw     <= 1'b0;
            mack_ok <= 1'b0;
            ptr     <= '0;
            wr_data <= '0;
            wr_stb  <= 1'b0;
            rd_stb  <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            rd_stb <= 1'b0;
            if (wr_stb || rd_stb) begin
                ptr <= ptr + PTR_STEP;
            end
            if (bus_stop) begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
            end else if (bus_start) begin
                state   <= ST_RX;
                phase   <= PH_ADDR;
                bitcnt  <= '0;
                got8    <= 1'b0;
                sda_low <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) got8 <= 1'b1;
                        end else if (scl_fall && got8) begin
                            got8    <= 1'b0;
                            bitcnt  <= '0;
                            state   <= ST_ACK;
                            sda_low <= 1'b1;
                            case (phase)
                                PH_ADDR: begin
                                    if (shreg[7:1] == DEV_ADDR) begin
                                        rnw   <= shreg[0];
                                        phase <= PH_PTR_HI;
                                    end else begin
                                        state   <= ST_SKIP;
                                        sda_low <= 1'b0;
                                    end
                                end
                                PH_PTR_HI: begin
                                    ptr[AW-1:8] <= shreg[AW-9:0];
                                    phase       <= PH_PTR_LO;
                                end
                                PH_PTR_LO: begin
                                    ptr[7:0] <= shreg;
                                    phase    <= PH_DATA;
                                end
                                default: begin
                                    wr_data <= shreg;
                                    wr_stb  <= 1'b1;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            if (rnw) begin
                                state  <= ST_LOAD;
                                rd_stb <= 1'b1;
                            end else begin
                                state <= ST_RX;
                            end
                        end
                    end
                    ST_LOAD: begin
                        shreg   <= rd_data;
                        sda_low <= ~rd_data[7];
                        bitcnt  <= '0;
                        state   <= ST_TX;
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                state   <= ST_MACK;
                                sda_low <= 1'b0;
                            end else begin
                                shreg   <= {shreg[6:0], 1'b0};
                                sda_low <= ~shreg[6];
                                bitcnt  <= bitcnt + 3'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mack_ok) begin
                                state  <= ST_LOAD;
                                rd_stb <= 1'b1;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_reg_policy.sv
// Local registers with special access rules (clear-on-read status,
// self-clearing reset, enable, read-only revision) and the write guard
// for the restricted window; everything else passes to the external bank.
// Assumes: strobes are single-cycle and addr is stable while they are high.
module i2c_reg_policy #(
    parameter int              AW        = 16,
    parameter int              EVW       = 8,
    parameter logic [AW-1:0]   SRST_ADDR = 16'h2000,
    parameter logic [AW-1:0]   STAT_ADDR = 16'h2001,
    parameter logic [AW-1:0]   CTRL_ADDR = 16'h20FF,
    parameter logic [AW-1:0]   REV_ADDR  = 16'h21FF,
    parameter logic [7:0]      REV_VALUE = 8'h41,
    parameter logic [AW-1:0]   PROT_LO   = 16'h2080,
    parameter logic [AW-1:0]   PROT_HI   = 16'h208F
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  addr,
    input  logic [7:0]     wr_data,
    input  logic           wr_stb,
    input  logic           rd_stb,
    input  logic [7:0]     ext_rdata,
    input  logic [EVW-1:0] evt,
    output logic [7:0]     rd_data,
    output logic           ext_wr,
    output logic           ext_rd,
    output logic           dev_en,
    output logic           soft_rst
);
    logic [EVW-1:0] status;
    logic           hit_srst, hit_stat, hit_ctrl, hit_rev, is_local, in_prot;

    // Address decode and external strobe gating.
    always_comb begin
        hit_srst = (addr == SRST_ADDR);
        hit_stat = (addr == STAT_ADDR);
        hit_ctrl = (addr == CTRL_ADDR);
        hit_rev  = (addr == REV_ADDR);
        is_local = hit_srst | hit_stat | hit_ctrl | hit_rev;
        in_prot  = (addr >= PROT_LO) && (addr <= PROT_HI);
        ext_wr   = wr_stb && !is_local && !(in_prot && dev_en);
        ext_rd   = rd_stb && !is_local;
    end

    // Read-data selection.
    always_comb begin
        rd_data = ext_rdata;
        if (hit_stat)      rd_data = 8'(status);
        else if (hit_ctrl) rd_data = {7'd0, dev_en};
        else if (hit_rev)  rd_data = REV_VALUE;
        else if (hit_srst) rd_data = 8'd0;
    end

    // Sticky status bits, cleared by a read of the status address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else if (rd_stb && hit_stat) begin
            status <= evt;
        end else begin
            status <= status | evt;
        end
    end

    // Enable bit and self-clearing reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_en   <= 1'b0;
            soft_rst <= 1'b0;
        end else if (wr_stb && hit_srst && wr_data[0]) begin
            dev_en   <= 1'b0;
            soft_rst <= 1'b1;
        end else begin
            soft_rst <= 1'b0;
            if (wr_stb && hit_ctrl) dev_en <= wr_data[0];
        end
    end

endmodule

// File: rtl/i2c_regtarget.sv
// Top of the I2C register target: synchroniser, protocol engine and
// access-policy layer. SDA is open-drain (sda_oe_o = 1 pulls low).
// Assumes: reg_rdata_i follows reg_addr_o combinationally.
module i2c_regtarget #(
    parameter int            AW        = 16,
    parameter int            SYNC      = 2,
    parameter logic [6:0]    DEV_ADDR  = 7'h39,
    parameter logic [AW-1:0] SRST_ADDR = 16'h2000,
    parameter logic [AW-1:0] STAT_ADDR = 16'h2001,
    parameter logic [AW-1:0] CTRL_ADDR = 16'h20FF,
    parameter logic [AW-1:0] REV_ADDR  = 16'h21FF,
    parameter logic [7:0]    REV_VALUE = 8'h41,
    parameter logic [AW-1:0] PROT_LO   = 16'h2080,
    parameter logic [AW-1:0] PROT_HI   = 16'h208F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    output logic [AW-1:0] reg_addr_o,
    output logic [7:0]    reg_wdata_o,
    output logic          reg_wr_o,
    output logic          reg_rd_o,
    input  logic [7:0]    reg_rdata_i,
    input  logic [7:0]    status_evt_i,
    output logic          dev_en_o,
    output logic          soft_rst_o
);
    logic       sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic       wr_stb, rd_stb;
    logic [7:0] rd_data;

    i2c_line_sync #(.STAGES(SYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop)
    );

    i2c_link_engine #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .bus_start(bus_start), .bus_stop(bus_stop),
        .rd_data(rd_data), .ptr(reg_addr_o), .wr_data(reg_wdata_o),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .sda_low(sda_oe_o)
    );

    i2c_reg_policy #(
        .AW(AW), .EVW(8), .SRST_ADDR(SRST_ADDR), .STAT_ADDR(STAT_ADDR),
        .CTRL_ADDR(CTRL_ADDR), .REV_ADDR(REV_ADDR), .REV_VALUE(REV_VALUE),
        .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
    ) u_policy (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr_o), .wr_data(reg_wdata_o),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .ext_rdata(reg_rdata_i),
        .evt(status_evt_i), .rd_data(rd_data), .ext_wr(reg_wr_o),
        .ext_rd(reg_rd_o), .dev_en(dev_en_o), .soft_rst(soft_rst_o)
    );

endmodule

// File: rtl/i2c_regtarget_chk.sv
// Port-level properties of the I2C register target, bound to the top.
// Assumes: SCL phases last longer than the synchroniser latency.
module i2c_regtarget_chk #(
    parameter int            AW        = 16,
    parameter logic [AW-1:0] SRST_ADDR = 16'h2000,
    parameter logic [AW-1:0] STAT_ADDR = 16'h2001,
    parameter logic [AW-1:0] CTRL_ADDR = 16'h20FF,
    parameter logic [AW-1:0] REV_ADDR  = 16'h21FF,
    parameter logic [AW-1:0] PROT_LO   = 16'h2080,
    parameter logic [AW-1:0] PROT_HI   = 16'h208F
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_i,
    input logic          sda_oe_o,
    input logic [AW-1:0] reg_addr_o,
    input logic          reg_wr_o,
    input logic          reg_rd_o,
    input logic          dev_en_o,
    input logic          soft_rst_o
);
    logic local_hit;
    assign local_hit = (reg_addr_o == SRST_ADDR) || (reg_addr_o == STAT_ADDR) ||
                       (reg_addr_o == CTRL_ADDR) || (reg_addr_o == REV_ADDR);

    p_wr_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_o && reg_rd_o));

    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    p_rst_disables_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> !dev_en_o);

    p_guard_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o && reg_addr_o >= PROT_LO && reg_addr_o <= PROT_HI) |-> !dev_en_o);

    p_local_hidden_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o || reg_rd_o) |-> !local_hit);

    p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> !scl_i);

endmodule

bind i2c_regtarget i2c_regtarget_chk #(
    .AW(AW), .SRST_ADDR(SRST_ADDR), .STAT_ADDR(STAT_ADDR),
    .CTRL_ADDR(CTRL_ADDR), .REV_ADDR(REV_ADDR),
    .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
    .reg_addr_o(reg_addr_o), .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o),
    .dev_en_o(dev_en_o), .soft_rst_o(soft_rst_o)
);

// File: tb/test_i2c_regtarget.sv
// Bench for the I2C register target: a bit-level bus controller model,
// a combinational external bank, and sweeps with computed expectations.
`timescale 1ns/1ps
module test_i2c_regtarget;
    localparam int         Q    = 5;
    localparam logic [6:0] DEV  = 7'h39;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_rdata;
    logic [7:0]  evt = 8'h00;
    logic        dev_en, soft_rst;
    wire         sda_line = sda_m & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    int srst_cnt = 0;
    bit done = 1'b0;

    logic [7:0] bank [0:255];
    logic [7:0] wbuf [0:31];
    logic [7:0] rbuf [0:31];
    logic       ack_all;

    always #10 clk = ~clk;

    i2c_regtarget i_i2c_regtarget (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
        .reg_wr_o(reg_wr), .reg_rd_o(reg_rd), .reg_rdata_i(reg_rdata),
        .status_evt_i(evt), .dev_en_o(dev_en), .soft_rst_o(soft_rst)
    );

    assign reg_rdata = bank[reg_addr[7:0]];

    // External bank model and strobe counters.
    always @(posedge clk) begin
        if (reg_wr) begin
            bank[reg_addr[7:0]] <= reg_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (reg_rd) rd_cnt <= rd_cnt + 1;
        if (soft_rst) begin
            srst_cnt <= srst_cnt + 1;
            for (int i = 0; i < 256; i++) bank[i] <= 8'h00;
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        sda_m = b; qw(); scl_m = 1'b1; qw(); r = sda_line; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
        bit_xfer(1'b1, r);
        ack = ~r;
    endtask

    task automatic rbyte(input logic mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, r);
            d[i] = r;
        end
        bit_xfer(~mack, r);
    endtask

    task automatic wr_burst(input logic [15:0] a, input int n);
        logic ack;
        ack_all = 1'b1;
        bus_start();
        wbyte({DEV, 1'b0}, ack); ack_all &= ack;
        wbyte(a[15:8], ack);     ack_all &= ack;
        wbyte(a[7:0], ack);      ack_all &= ack;
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], ack); ack_all &= ack;
        end
        bus_stop();
    endtask

    task automatic rd_burst(input logic [15:0] a, input int n);
        logic ack;
        ack_all = 1'b1;
        bus_start();
        wbyte({DEV, 1'b0}, ack); ack_all &= ack;
        wbyte(a[15:8], ack);     ack_all &= ack;
        wbyte(a[7:0], ack);      ack_all &= ack;
        bus_start();
        wbyte({DEV, 1'b1}, ack); ack_all &= ack;
        for (int i = 0; i < n; i++) rbyte(i != n - 1, rbuf[i]);
        qw();
        chk("R3 sda released after nack", {31'd0, sda_oe}, 32'd0);
        bus_stop();
    endtask

    task automatic wr_one(input logic [15:0] a, input logic [7:0] d);
        wbuf[0] = d;
        wr_burst(a, 1);
    endtask

    task automatic rd_one(input logic [15:0] a, output logic [7:0] d);
        rd_burst(a, 1);
        d = rbuf[0];
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog got=hang exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int          base_w;
        int          c0;
        logic [7:0]  d;
        logic        ack;
        logic        r;
        for (int i = 0; i < 256; i++) bank[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Reset state (R11, R7).
        chk("R11 reset sda", {31'd0, sda_oe}, 32'd0);
        chk("R7 reset enable", {31'd0, dev_en}, 32'd0);
        chk("R6 reset pulse idle", {31'd0, soft_rst}, 32'd0);

        // R1: address sweep, only DEV is acknowledged.
        for (int a = 0; a < 128; a++) begin
            bus_start();
            wbyte({7'(a), 1'b0}, ack);
            bus_stop();
            chk("R1 address match", {31'd0, ack}, {31'd0, (a == int'(DEV))});
        end
        // R1: after a foreign address, later bytes are ignored.
        c0 = wr_cnt;
        bus_start();
        wbyte({7'h3A, 1'b0}, ack);
        wbyte(8'h10, r); ack |= r;
        wbyte(8'h10, r); ack |= r;
        wbyte(8'hEE, r); ack |= r;
        bus_stop();
        chk("R1 ignored after nack", {31'd0, ack}, 32'd0);
        chk("R1 no write after nack", wr_cnt - c0, 32'd0);

        // R2/R3: burst write and read back, several lengths and patterns.
        for (int len = 1; len <= 6; len++) begin
            base_w = 16'h1010 + len * 8;
            for (int i = 0; i < len; i++) wbuf[i] = 8'((i * 37 + len * 11 + 5) ^ (len << 4));
            c0 = wr_cnt;
            wr_burst(16'(base_w), len);
            chk("R2 all bytes acked", {31'd0, ack_all}, 32'd1);
            chk("R2 one strobe per byte", wr_cnt - c0, 32'(len));
            for (int i = 0; i < len; i++)
                chk("R2 stored value", {24'd0, bank[8'(base_w + i)]}, {24'd0, wbuf[i]});
            c0 = rd_cnt;
            rd_burst(16'(base_w), len);
            chk("R3 read strobes", rd_cnt - c0, 32'(len));
            for (int i = 0; i < len; i++)
                chk("R3 read value", {24'd0, rbuf[i]}, {24'd0, wbuf[i]});
        end

        // R2: pointer wraps from 0xFFFF to 0x0000.
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3;
        wr_burst(16'hFFFE, 3);
        chk("R2 wrap FE", {24'd0, bank[8'hFE]}, 32'hC1);
        chk("R2 wrap FF", {24'd0, bank[8'hFF]}, 32'hC2);
        chk("R2 wrap 00", {24'd0, bank[8'h00]}, 32'hC3);
        rd_burst(16'hFFFF, 2);
        chk("R3 read wrap", {16'd0, rbuf[0], rbuf[1]}, 32'hC2C3);

        // R4: STOP inside a data byte, then START inside a data byte.
        wr_one(16'h1005, 8'h5A);
        c0 = wr_cnt;
        bus_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'h10, ack);
        wbyte(8'h05, ack);
        for (int i = 0; i < 4; i++) bit_xfer(1'b0, r);
        bus_stop();
        chk("R4 stop mid-byte", wr_cnt - c0, 32'd0);
        bus_start();
        wbyte({DEV, 1'b0}, ack);
        wbyte(8'h10, ack);
        wbyte(8'h05, ack);
        for (int i = 0; i < 7; i++) bit_xfer(1'b1, r);
        bus_start();
        wbyte({DEV, 1'b0}, ack);
        bus_stop();
        chk("R4 start mid-byte", wr_cnt - c0, 32'd0);
        rd_one(16'h1005, d);
        chk("R4 value kept", {24'd0, d}, 32'h5A);

        // R5: status collects events and clears on read.
        @(negedge clk); evt = 8'h81;
        @(negedge clk); evt = 8'h00;
        repeat (3) @(negedge clk); evt = 8'h04;
        @(negedge clk); evt = 8'h00;
        c0 = rd_cnt;
        rd_one(16'h2001, d);
        chk("R5 status read", {24'd0, d}, 32'h85);
        rd_one(16'h2001, d);
        chk("R5 status cleared", {24'd0, d}, 32'h00);
        chk("R10 no external read", rd_cnt - c0, 32'd0);

        // R7: enable register.
        c0 = wr_cnt;
        wr_one(16'h20FF, 8'h01);
        chk("R7 enable out", {31'd0, dev_en}, 32'd1);
        rd_one(16'h20FF, d);
        chk("R7 enable readback", {24'd0, d}, 32'h01);
        chk("R10 no external write", wr_cnt - c0, 32'd0);

        // R8: window 0x2080..0x208F guarded while enabled, edges free.
        for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'hA0 + i);
        c0 = wr_cnt;
        wr_burst(16'h207F, 18);
        chk("R8 acked while guarded", {31'd0, ack_all}, 32'd1);
        chk("R8 only edges written", wr_cnt - c0, 32'd2);
        chk("R8 below window", {24'd0, bank[8'h7F]}, 32'hA0);
        chk("R8 above window", {24'd0, bank[8'h90]}, 32'hB1);
        for (int i = 0; i < 16; i++)
            chk("R8 window unchanged", {24'd0, bank[8'h80 + i]}, 32'h00);
        wr_one(16'h20FF, 8'h00);
        c0 = wr_cnt;
        wr_burst(16'h207F, 18);
        chk("R8 open when disabled", wr_cnt - c0, 32'd18);
        for (int i = 0; i < 16; i++)
            chk("R8 window written", {24'd0, bank[8'h80 + i]}, {24'd0, wbuf[i + 1]});

        // R6: reset bit.
        wr_one(16'h20FF, 8'h01);
        c0 = srst_cnt;
        wr_one(16'h2000, 8'h00);
        chk("R6 zero write no pulse", srst_cnt - c0, 32'd0);
        chk("R6 zero write keeps enable", {31'd0, dev_en}, 32'd1);
        wr_one(16'h2000, 8'h01);
        chk("R6 one pulse", srst_cnt - c0, 32'd1);
        chk("R6 enable cleared", {31'd0, dev_en}, 32'd0);
        rd_one(16'h2000, d);
        chk("R6 reads zero", {24'd0, d}, 32'h00);
        rd_one(16'h2080, d);
        chk("R6 external bank reset", {24'd0, d}, 32'h00);

        // R9: revision is read-only.
        rd_one(16'h21FF, d);
        chk("R9 revision", {24'd0, d}, 32'h41);
        c0 = wr_cnt;
        wr_one(16'h21FF, 8'h00);
        rd_one(16'h21FF, d);
        chk("R9 revision after write", {24'd0, d}, 32'h41);
        chk("R10 revision write hidden", wr_cnt - c0, 32'd0);
        chk("R11 idle released", {31'd0, sda_oe}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule